// File: doc/BRIEF.md
# UART DMA Ready Signal Generator

This block drives the two active-low handshake lines that a DMA controller watches when it services a UART: one that asks for more transmit data and one that reports receive data to collect. It does not hold any data. It reads the fill levels of the transmit and receive FIFOs, the state of the single-character holding registers, and a few configuration bits. From these it decides, once per clock, whether each direction is ready. Both decisions are registered, so the outputs change one clock after the inputs that cause them.

There are two transfer behaviours. Single-transfer behaviour copies a one-character holding register: transmit is ready when nothing is waiting to be sent, and receive is ready when a character is present. Block behaviour uses FIFO thresholds. Transmit stays ready while any FIFO slot is free. Receive becomes ready once the fill reaches a selectable trigger, and it remains ready until the FIFO has been drained to empty. The FIFO itself keeps accepting characters above the trigger until it is full. When the FIFOs are switched off, single-transfer behaviour applies whatever the mode bit says. The two ready states are also given as active-high status bits for host reads. Matching interrupt requests are raised only when the enhanced-feature enable is set.

Top module: `uart_dma_ready`

## Requirements
- R1: While `rst` is high and on the first clock after it, `tx_rdy_n` and `rx_rdy_n` are 1, and `rdy_stat`, `tx_irq` and `rx_irq` are 0.
- R2: In single-transfer behaviour, `tx_rdy_n` is 0 one clock after `thr_empty` is 1 (FIFOs off), or one clock after `tx_level` is 0 (FIFOs on). Otherwise it is 1.
- R3: In single-transfer behaviour, `rx_rdy_n` is 0 one clock after `rhr_full` is 1 (FIFOs off), or one clock after `rx_level` is non-zero (FIFOs on). Otherwise it is 1.
- R4: In block behaviour (`fifo_en`=1 and `dma_mode`=1), `tx_rdy_n` is 0 one clock after `tx_level` is below DEPTH, and 1 one clock after `tx_level` equals DEPTH.
- R5: In block behaviour, `rx_rdy_n` goes to 0 one clock after `rx_level` reaches the trigger. `rx_trig_sel` encodes the trigger as 0→1, 1→DEPTH/4, 2→DEPTH/2 and 3→DEPTH-2; with DEPTH=16 these are 1, 4, 8 and 14.
- R6: In block behaviour, once `rx_rdy_n` is 0 it stays 0 while `rx_level` is non-zero, including fills below the trigger. It returns to 1 one clock after `rx_level` is 0. Fills above the trigger, up to DEPTH, keep it at 0.
- R7: With `fifo_en`=0, `dma_mode` has no effect, and both outputs follow R2 and R3.
- R8: `rdy_stat[0]` is the inverse of `tx_rdy_n`, and `rdy_stat[1]` is the inverse of `rx_rdy_n`, on every cycle.
- R9: `tx_irq` and `rx_irq` are 0 one clock after `enh_en` is 0. With `enh_en`=1, `rx_irq` equals the receive ready state. `tx_irq` equals the transmit ready state in single-transfer behaviour, and in block behaviour it is 1 exactly when `tx_level` is below TX_THR (default 8).
- R10: Leaving block behaviour forgets the receive hold. On re-entry, `rx_rdy_n` stays 1 until the fill reaches the trigger again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFOs enabled |
| dma_mode | input | 1 | 0 single-transfer, 1 block |
| enh_en | input | 1 | Enhanced-feature enable; gates interrupts |
| rx_trig_sel | input | 2 | Receive trigger select |
| thr_empty | input | 1 | Transmit holding register empty (FIFOs off) |
| rhr_full | input | 1 | Receive holding register holds a character (FIFOs off) |
| tx_level | input | CNT_W | Transmit FIFO fill count |
| rx_level | input | CNT_W | Receive FIFO fill count |
| tx_rdy_n | output | 1 | Transmit ready to DMA, active low |
| rx_rdy_n | output | 1 | Receive ready to DMA, active low |
| rdy_stat | output | 2 | Status mirror: bit 0 transmit, bit 1 receive, active high |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The only hidden state is the receive hold flag used in block behaviour. If it is wrong, the error shows on `rx_rdy_n` and `rx_irq` one clock after the fill drops below the trigger without reaching zero: the line rises early or fails to rise later. The trigger sweep and the drain-to-empty sequences expose it within a single step. The bench compares every cycle, so a wrong decode of `tx_level`, a wrong trigger table entry or a wrong mode selection appears on the first clock after the offending input.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_BLOCK  = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/uart_dma_trig_dec.sv
module uart_dma_trig_dec #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] trig_lvl
);
  localparam logic [CNT_W-1:0] LVL_MIN  = CNT_W'(1);
  localparam logic [CNT_W-1:0] LVL_QTR  = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] LVL_HALF = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] LVL_HIGH = CNT_W'(DEPTH - 2);

  always_comb begin
    unique case (sel)
      2'd0:    trig_lvl = LVL_MIN;
      2'd1:    trig_lvl = LVL_QTR;
      2'd2:    trig_lvl = LVL_HALF;
      default: trig_lvl = LVL_HIGH;
    endcase
  end
endmodule

// File: rtl/uart_dma_tx_ready.sv
module uart_dma_tx_ready
  import uart_dma_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int TX_THR = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  xfer_mode_e       mode,
  input  logic             fifo_en,
  input  logic             enh_en,
  input  logic             thr_empty,
  input  logic [CNT_W-1:0] tx_level,
  output logic             tx_rdy_n,
  output logic             tx_stat,
  output logic             tx_irq
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] THR_LVL  = CNT_W'(TX_THR);

  logic rdy_nx, irq_cond;

  always_comb begin
    if (mode == XFER_BLOCK) begin
      rdy_nx   = (tx_level < FULL_LVL);
      irq_cond = (tx_level < THR_LVL);
    end else begin
      rdy_nx   = fifo_en ? (tx_level == '0) : thr_empty;
      irq_cond = rdy_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_rdy_n <= 1'b1;
      tx_stat  <= 1'b0;
      tx_irq   <= 1'b0;
    end else begin
      tx_rdy_n <= ~rdy_nx;
      tx_stat  <= rdy_nx;
      tx_irq   <= enh_en & irq_cond;
    end
  end

  a_r4_full_blocks_tx: assert property (@(posedge clk) disable iff (rst)
    (mode == XFER_BLOCK && tx_level == FULL_LVL) |=> tx_rdy_n);
  a_r4_space_readies_tx: assert property (@(posedge clk) disable iff (rst)
    (mode == XFER_BLOCK && tx_level < FULL_LVL) |=> !tx_rdy_n);
  a_r9_tx_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !enh_en |=> !tx_irq);
endmodule

// File: rtl/uart_dma_rx_ready.sv
module uart_dma_rx_ready
  import uart_dma_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  xfer_mode_e       mode,
  input  logic             fifo_en,
  input  logic             enh_en,
  input  logic             rhr_full,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] trig_lvl,
  output logic             rx_rdy_n,
  output logic             rx_stat,
  output logic             rx_irq
);
  logic hold_q, hold_nx, rdy_nx;

  // Block behaviour: set at trigger, release only at empty.
  always_comb begin
    if (mode != XFER_BLOCK)       hold_nx = 1'b0;
    else if (rx_level == '0)      hold_nx = 1'b0;
    else if (rx_level >= trig_lvl) hold_nx = 1'b1;
    else                          hold_nx = hold_q;
  end

  always_comb begin
    if (mode == XFER_BLOCK) rdy_nx = hold_nx;
    else                    rdy_nx = fifo_en ? (rx_level != '0) : rhr_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= 1'b0;
      rx_rdy_n <= 1'b1;
      rx_stat  <= 1'b0;
      rx_irq   <= 1'b0;
    end else begin
      hold_q   <= hold_nx;
      rx_rdy_n <= ~rdy_nx;
      rx_stat  <= rdy_nx;
      rx_irq   <= enh_en & rdy_nx;
    end
  end

  a_r5_trigger_sets_rx: assert property (@(posedge clk) disable iff (rst)
    (mode == XFER_BLOCK && rx_level >= trig_lvl && rx_level != '0) |=> !rx_rdy_n);
  a_r6_empty_clears_rx: assert property (@(posedge clk) disable iff (rst)
    (mode == XFER_BLOCK && rx_level == '0) |=> rx_rdy_n);
  a_r6_hold_until_empty: assert property (@(posedge clk) disable iff (rst)
    (mode == XFER_BLOCK && $past(mode) == XFER_BLOCK && !rx_rdy_n && rx_level != '0)
      |=> !rx_rdy_n);
  a_r9_rx_irq_gated: assert property (@(posedge clk) disable iff (rst)
    !enh_en |=> !rx_irq);
endmodule

// File: rtl/uart_dma_ready.sv
module uart_dma_ready
  import uart_dma_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TX_THR = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             dma_mode,
  input  logic             enh_en,
  input  logic [1:0]       rx_trig_sel,
  input  logic             thr_empty,
  input  logic             rhr_full,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_level,
  output logic             tx_rdy_n,
  output logic             rx_rdy_n,
  output logic [1:0]       rdy_stat,
  output logic             tx_irq,
  output logic             rx_irq
);
  xfer_mode_e       mode;
  logic [CNT_W-1:0] trig_lvl;
  logic             tx_stat, rx_stat;

  // FIFOs off forces single-transfer behaviour.
  assign mode = (fifo_en && dma_mode) ? XFER_BLOCK : XFER_SINGLE;

  uart_dma_trig_dec #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
    .sel      (rx_trig_sel),
    .trig_lvl (trig_lvl)
  );

  uart_dma_tx_ready #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TX_THR(TX_THR)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .fifo_en   (fifo_en),
    .enh_en    (enh_en),
    .thr_empty (thr_empty),
    .tx_level  (tx_level),
    .tx_rdy_n  (tx_rdy_n),
    .tx_stat   (tx_stat),
    .tx_irq    (tx_irq)
  );

  uart_dma_rx_ready #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .fifo_en  (fifo_en),
    .enh_en   (enh_en),
    .rhr_full (rhr_full),
    .rx_level (rx_level),
    .trig_lvl (trig_lvl),
    .rx_rdy_n (rx_rdy_n),
    .rx_stat  (rx_stat),
    .rx_irq   (rx_irq)
  );

  assign rdy_stat = {rx_stat, tx_stat};

  a_r7_fifo_off_single_tx: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && thr_empty) |=> !tx_rdy_n);
  a_r7_fifo_off_single_rx: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && !rhr_full) |=> rx_rdy_n);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (tx_rdy_n && rx_rdy_n && !tx_irq && !rx_irq));
endmodule

// File: tb/uart_dma_ready_tb.sv
module uart_dma_ready_tb;
  localparam int DEPTH  = 16;
  localparam int TX_THR = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 0, dma_mode = 0, enh_en = 0, thr_empty = 0, rhr_full = 0;
  logic [1:0] rx_trig_sel = 0;
  logic [CNT_W-1:0] tx_level = 0, rx_level = 0;
  logic tx_rdy_n, rx_rdy_n, tx_irq, rx_irq;
  logic [1:0] rdy_stat;

  int checks = 0;
  int errors = 0;
  bit m_hold = 0;
  bit m_tx = 0, m_rx = 0, m_tirq = 0, m_rirq = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  uart_dma_ready #(.DEPTH(DEPTH), .TX_THR(TX_THR)) u_dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode),
    .enh_en(enh_en), .rx_trig_sel(rx_trig_sel), .thr_empty(thr_empty),
    .rhr_full(rhr_full), .tx_level(tx_level), .rx_level(rx_level),
    .tx_rdy_n(tx_rdy_n), .rx_rdy_n(rx_rdy_n), .rdy_stat(rdy_stat),
    .tx_irq(tx_irq), .rx_irq(rx_irq));

  function automatic int trig_of(input int sel);
    case (sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  // Behavioural reference, evaluated at each clock edge.
  task automatic model_edge();
    bit blk;
    int tl, rl;
    blk = fifo_en && dma_mode;
    tl = int'(tx_level);
    rl = int'(rx_level);
    if (rst) begin
      m_hold = 0; m_tx = 0; m_rx = 0; m_tirq = 0; m_rirq = 0;
      return;
    end
    if (!blk || rl == 0) m_hold = 0;
    else if (rl >= trig_of(int'(rx_trig_sel))) m_hold = 1;
    if (blk) begin
      m_tx = tl < DEPTH;
      m_rx = m_hold;
      m_tirq = enh_en && (tl < TX_THR);
    end else begin
      m_tx = fifo_en ? (tl == 0) : thr_empty;
      m_rx = fifo_en ? (rl != 0) : rhr_full;
      m_tirq = enh_en && m_tx;
    end
    m_rirq = enh_en && m_rx;
  endtask

  task automatic compare();
    logic [5:0] act, exp;
    act = {tx_rdy_n, rx_rdy_n, rdy_stat, tx_irq, rx_irq};
    exp = {~m_tx, ~m_rx, m_rx, m_tx, m_tirq, m_rirq};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b (txn rxn stat[1:0] tirq rirq) t=%0t",
               tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic set_cfg(input bit fe, input bit dm, input bit en, input int ts);
    fifo_en = fe; dma_mode = dm; enh_en = en; rx_trig_sel = 2'(ts);
  endtask

  task automatic lv(input int t, input int r);
    tx_level = CNT_W'(t); rx_level = CNT_W'(r);
    step();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1 reset";
    rst = 1; thr_empty = 1; rhr_full = 1; enh_en = 1;
    step(); step();
    @(negedge clk);
    rst = 0; thr_empty = 0; rhr_full = 0; enh_en = 0;

    tag = "R2 R8 single tx fifo off";
    set_cfg(0, 0, 1, 0);
    thr_empty = 1; step(); thr_empty = 0; step(); thr_empty = 1; step();

    tag = "R3 R8 single rx fifo off";
    rhr_full = 1; step(); rhr_full = 0; step(); rhr_full = 1; step();

    tag = "R7 mode bit ignored when fifo off";
    set_cfg(0, 1, 1, 2);
    thr_empty = 0; rhr_full = 1; lv(3, 10);
    thr_empty = 1; rhr_full = 0; lv(DEPTH, 0);
    rhr_full = 1; lv(0, 5);

    tag = "R2 R3 single with fifo on";
    set_cfg(1, 0, 1, 0);
    thr_empty = 0; rhr_full = 0;
    lv(0, 0); lv(5, 1); lv(0, 3); lv(1, 0);

    tag = "R4 R9 block tx levels";
    set_cfg(1, 1, 1, 3);
    for (int t = 0; t <= DEPTH; t++) lv(t, 0);
    lv(DEPTH - 1, 0); lv(DEPTH, 0); lv(TX_THR, 0); lv(TX_THR - 1, 0);

    for (int s = 0; s < 4; s++) begin
      set_cfg(1, 1, 1, s);
      tag = "R5 block rx fill sweep";
      for (int r = 0; r <= DEPTH; r++) lv(0, r);
      tag = "R6 block rx drain to empty";
      for (int r = DEPTH; r >= 0; r--) lv(0, r);
      tag = "R6 R5 partial fill below trigger";
      lv(0, 1); lv(0, trig_of(s) - 1 > 0 ? trig_of(s) - 1 : 1); lv(0, 0);
    end

    tag = "R10 hold forgotten across mode change";
    set_cfg(1, 1, 1, 2);
    lv(0, 10); lv(0, 5);
    dma_mode = 0; lv(0, 5);
    dma_mode = 1; lv(0, 5); lv(0, 7); lv(0, 8); lv(0, 3);
    fifo_en = 0; lv(0, 3);
    fifo_en = 1; lv(0, 3);

    tag = "R9 interrupts masked";
    set_cfg(1, 1, 0, 0);
    lv(2, 5); lv(DEPTH, 0); lv(0, 9);
    set_cfg(0, 0, 0, 0); thr_empty = 1; rhr_full = 1; lv(0, 0);
    enh_en = 1; lv(0, 0);

    tag = "R1 reset mid-run";
    set_cfg(1, 1, 1, 0);
    lv(0, 16);
    rst = 1; step();
    rst = 0; lv(0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule